// File: doc/BRIEF.md
# Cache Fill Reply Sequencer

This block takes the memory reply for an outstanding second-level miss and installs the returned line. It handles three kinds of reply. An upgrade turns a line the cache already holds into a writable line. A present-line fill rewrites a way whose tag is still held but whose line is invalid. A total miss fills a victim way picked by an external replacement unit. Victim choice and data storage are outside this block. The block drives a line-state write port, invalidation pushes toward the upper instruction and data caches, and one shared data pipe that carries writebacks and replies.

Each reply is worked through as a sequence of steps, and any step can stall. The line is installed first. The invalidations go out next, but only when both upper queues have room. If the upper data cache is write-back, the block then waits for the acknowledgement of that invalidation. Any dirty victim is then sent down the pipe, and the reply follows it. When the reply has been accepted, a release pulse tells the miss holding register to hand the reply kind to every request merged into it. A stall input freezes the whole sequence.

Top module: `fill_seq`

## Requirements
- R1: `rep_ready` is high only while the block is idle. It is high out of reset and goes low the cycle after a reply is accepted. It stays low until the release pulse of that reply.
- R2: An upgrade reply (`rep_kind`=0) writes state 3 (private-dirty) to `rep_way`. It sends no invalidation and no writeback, and it releases with kind 2.
- R3: A present-line reply (`rep_kind`=1) writes `rep_way` and makes no replacement. Victim inputs have no effect on it.
- R4: Line states are encoded 0 invalid, 1 shared-clean, 2 private-clean, 3 private-dirty. A non-upgrade fill writes 3 if `rep_has_wr` is set. Otherwise it writes 2 for an exclusive reply (`rep_excl`=1) and 1 for a shared reply. A line write never carries state 0.
- R5: A total-miss reply (`rep_kind`=2 or 3) writes `vict_way`. While `vict_valid` is low it makes no line write and retries every cycle.
- R6: A total miss whose victim state is not 0 pushes exactly one invalidation on each upper port. The push carries the reply set and `vict_tag`. A victim in state 0 causes no push.
- R7: Invalidation pushes happen only in a cycle where both `inv_i_full` and `inv_d_full` are low. Otherwise the step waits, and both pushes happen in the same cycle.
- R8: A victim in state 3 produces exactly one writeback on the data pipe (`pipe_kind`=3, tag `vict_tag`), accepted before the reply.
- R9: With `l1_wb_mode` high and an invalidation sent, the block sends nothing down the pipe until `inv_ack_valid`. If `inv_ack_wb` is set, a clean victim gets a writeback, and a dirty victim still gets only one.
- R10: While `pipe_valid` is high and `pipe_ready` low, the pipe entry stays valid with the same kind and tag, unless `stall_reply` is high.
- R11: The reply enters the pipe with `pipe_kind` 0 for shared, 1 for exclusive and 2 for upgrade. In the cycle it is accepted, `rel_valid` pulses once with the same code on `rel_kind`.
- R12: While `stall_reply` is high, there is no line write, no invalidation push, no pipe valid and no release, and the step does not advance. The only exception is that an acknowledgement in the wait step is still taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_reply | input | 1 | Freeze sequencing |
| rep_valid | input | 1 | Reply present |
| rep_ready | output | 1 | Reply accepted when high |
| rep_kind | input | 2 | 0 upgrade, 1 present line, 2/3 total miss |
| rep_excl | input | 1 | Exclusive reply (else shared) |
| rep_has_wr | input | 1 | A merged request writes |
| rep_set | input | SET_W | Set index of the line |
| rep_tag | input | TAG_W | Tag of the returned line |
| rep_way | input | WAY_W | Way for upgrade and present-line replies |
| vict_valid | input | 1 | A victim way is available |
| vict_way | input | WAY_W | Chosen victim way |
| vict_state | input | 2 | Current state of the victim |
| vict_tag | input | TAG_W | Tag held by the victim |
| l1_wb_mode | input | 1 | Upper data cache is write-back |
| inv_i_full | input | 1 | Upper instruction queue full |
| inv_d_full | input | 1 | Upper data queue full |
| inv_i_push | output | 1 | Push invalidation to instruction queue |
| inv_d_push | output | 1 | Push invalidation to data queue |
| inv_set | output | SET_W | Invalidation set |
| inv_tag | output | TAG_W | Invalidation tag |
| inv_ack_valid | input | 1 | Upper invalidation acknowledgement |
| inv_ack_wb | input | 1 | Acknowledgement carried written-back data |
| pipe_valid | output | 1 | Data pipe entry valid |
| pipe_ready | input | 1 | Data pipe accepts entry |
| pipe_kind | output | 2 | 0/1/2 reply kind, 3 writeback |
| pipe_set | output | SET_W | Entry set |
| pipe_tag | output | TAG_W | Entry tag |
| st_we | output | 1 | Line state write |
| st_set | output | SET_W | Written set |
| st_way | output | WAY_W | Written way |
| st_tag | output | TAG_W | Written tag |
| st_state | output | 2 | Written line state |
| rel_valid | output | 1 | Release pulse for the miss register |
| rel_kind | output | 2 | Reply kind handed to merged requests |

## Verification
The bench goes after four kinds of corner case. The first is a clean victim that only becomes dirty through the acknowledgement's writeback flag. A design that ignored the flag would lose the data, and one that waited in the wrong step would send the reply before the acknowledgement. The second is a dirty victim under the same flag, where a careless design would push a second writeback. The third is one upper queue full while the other has room: a design that checked a single flag would push into a full queue or split the pair across cycles. The fourth is a stall and a missing victim during install, which must leave no line write behind. Pipe backpressure must hold the writeback entry unchanged rather than drop it or let the reply overtake it.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SC  = 2'd1,
    LS_PC  = 2'd2,
    LS_PD  = 2'd3
  } line_st_e;

  localparam logic [1:0] RK_UPG  = 2'd0;
  localparam logic [1:0] RK_PRES = 2'd1;

  localparam logic [1:0] PK_SH  = 2'd0;
  localparam logic [1:0] PK_EX  = 2'd1;
  localparam logic [1:0] PK_UPG = 2'd2;
  localparam logic [1:0] PK_WB  = 2'd3;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_INST   = 3'd1,
    SQ_INVL   = 3'd2,
    SQ_WAITWB = 3'd3,
    SQ_SENDWB = 3'd4,
    SQ_SENDRP = 3'd5
  } seq_e;
endpackage

// File: rtl/fs_decode.sv
module fs_decode
  import fs_pkg::*;
#(
  parameter int WAY_W = 3
) (
  input  logic [1:0]       kind,
  input  logic             excl,
  input  logic             has_wr,
  input  logic [WAY_W-1:0] own_way,
  input  logic [WAY_W-1:0] vict_way,
  input  logic [1:0]       vict_state,
  output logic [1:0]       new_state,
  output logic [WAY_W-1:0] tgt_way,
  output logic             need_victim,
  output logic             need_inv,
  output logic             need_wb,
  output logic [1:0]       rel_kind
);
  line_st_e fill_st;

  always_comb begin
    need_victim = (kind != RK_UPG) && (kind != RK_PRES);
    need_inv    = need_victim && (line_st_e'(vict_state) != LS_INV);
    need_wb     = need_victim && (line_st_e'(vict_state) == LS_PD);
    tgt_way     = need_victim ? vict_way : own_way;

    if (kind == RK_UPG || has_wr) fill_st = LS_PD;
    else if (excl)                fill_st = LS_PC;
    else                          fill_st = LS_SC;
    new_state = fill_st;

    if (kind == RK_UPG) rel_kind = PK_UPG;
    else if (excl)      rel_kind = PK_EX;
    else                rel_kind = PK_SH;
  end
endmodule

// File: rtl/fs_ctrl.sv
module fs_ctrl
  import fs_pkg::*;
#(
  parameter int SET_W = 8,
  parameter int WAY_W = 3,
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall,
  input  logic             rep_valid,
  input  logic [1:0]       rep_kind,
  input  logic             rep_excl,
  input  logic             rep_has_wr,
  input  logic [SET_W-1:0] rep_set,
  input  logic [TAG_W-1:0] rep_tag,
  input  logic [WAY_W-1:0] rep_way,
  output logic             rep_ready,
  output logic [1:0]       c_kind,
  output logic             c_excl,
  output logic             c_wr,
  output logic [SET_W-1:0] c_set,
  output logic [TAG_W-1:0] c_tag,
  output logic [WAY_W-1:0] c_way,
  input  logic             d_need_victim,
  input  logic             d_need_inv,
  input  logic             d_need_wb,
  input  logic             vict_valid,
  input  logic [TAG_W-1:0] vict_tag,
  input  logic             l1_wb_mode,
  input  logic             q_i_full,
  input  logic             q_d_full,
  input  logic             ack_valid,
  input  logic             ack_wb,
  input  logic             pipe_ready,
  output logic             inst_go,
  output logic             inv_go,
  output logic             pipe_req,
  output logic             pipe_wb_sel,
  output logic             rel_go,
  output logic [TAG_W-1:0] v_tag
);
  seq_e step;
  logic wb_pend;

  always_comb begin
    rep_ready   = (step == SQ_IDLE);
    inst_go     = (step == SQ_INST) && !stall && (!d_need_victim || vict_valid);
    inv_go      = (step == SQ_INVL) && !stall && !q_i_full && !q_d_full;
    pipe_wb_sel = (step == SQ_SENDWB);
    pipe_req    = !stall && (((step == SQ_SENDWB) && wb_pend) || (step == SQ_SENDRP));
    rel_go      = (step == SQ_SENDRP) && pipe_req && pipe_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step    <= SQ_IDLE;
      wb_pend <= 1'b0;
      v_tag   <= '0;
      c_kind  <= '0;
      c_excl  <= 1'b0;
      c_wr    <= 1'b0;
      c_set   <= '0;
      c_tag   <= '0;
      c_way   <= '0;
    end else begin
      case (step)
        SQ_IDLE: if (rep_valid) begin
          c_kind <= rep_kind;
          c_excl <= rep_excl;
          c_wr   <= rep_has_wr;
          c_set  <= rep_set;
          c_tag  <= rep_tag;
          c_way  <= rep_way;
          step   <= SQ_INST;
        end
        SQ_INST: if (inst_go) begin
          wb_pend <= d_need_wb;
          v_tag   <= vict_tag;
          step    <= d_need_inv ? SQ_INVL : SQ_SENDRP;
        end
        SQ_INVL: if (inv_go) step <= l1_wb_mode ? SQ_WAITWB : SQ_SENDWB;
        SQ_WAITWB: if (ack_valid) begin
          if (ack_wb) wb_pend <= 1'b1;
          step <= SQ_SENDWB;
        end
        SQ_SENDWB: begin
          if (!wb_pend && !stall)          step <= SQ_SENDRP;
          else if (pipe_req && pipe_ready) step <= SQ_SENDRP;
        end
        SQ_SENDRP: if (rel_go) begin
          wb_pend <= 1'b0;
          step    <= SQ_IDLE;
        end
        default: step <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fs_pipe_mux.sv
module fs_pipe_mux
  import fs_pkg::*;
#(
  parameter int SET_W = 8,
  parameter int TAG_W = 20
) (
  input  logic             req,
  input  logic             wb_sel,
  input  logic [SET_W-1:0] set_i,
  input  logic [TAG_W-1:0] rep_tag,
  input  logic [TAG_W-1:0] vic_tag,
  input  logic [1:0]       rep_kind,
  output logic             valid,
  output logic [1:0]       kind,
  output logic [SET_W-1:0] set_o,
  output logic [TAG_W-1:0] tag
);
  always_comb begin
    valid = req;
    set_o = set_i;
    kind  = wb_sel ? PK_WB : rep_kind;
    tag   = wb_sel ? vic_tag : rep_tag;
  end
endmodule

// File: rtl/fill_seq.sv
module fill_seq
  import fs_pkg::*;
#(
  parameter int SET_W = 8,
  parameter int WAY_W = 3,
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall_reply,
  input  logic             rep_valid,
  output logic             rep_ready,
  input  logic [1:0]       rep_kind,
  input  logic             rep_excl,
  input  logic             rep_has_wr,
  input  logic [SET_W-1:0] rep_set,
  input  logic [TAG_W-1:0] rep_tag,
  input  logic [WAY_W-1:0] rep_way,
  input  logic             vict_valid,
  input  logic [WAY_W-1:0] vict_way,
  input  logic [1:0]       vict_state,
  input  logic [TAG_W-1:0] vict_tag,
  input  logic             l1_wb_mode,
  input  logic             inv_i_full,
  input  logic             inv_d_full,
  output logic             inv_i_push,
  output logic             inv_d_push,
  output logic [SET_W-1:0] inv_set,
  output logic [TAG_W-1:0] inv_tag,
  input  logic             inv_ack_valid,
  input  logic             inv_ack_wb,
  output logic             pipe_valid,
  input  logic             pipe_ready,
  output logic [1:0]       pipe_kind,
  output logic [SET_W-1:0] pipe_set,
  output logic [TAG_W-1:0] pipe_tag,
  output logic             st_we,
  output logic [SET_W-1:0] st_set,
  output logic [WAY_W-1:0] st_way,
  output logic [TAG_W-1:0] st_tag,
  output logic [1:0]       st_state,
  output logic             rel_valid,
  output logic [1:0]       rel_kind
);
  logic [1:0]       c_kind;
  logic             c_excl, c_wr;
  logic [SET_W-1:0] c_set;
  logic [TAG_W-1:0] c_tag, v_tag;
  logic [WAY_W-1:0] c_way, tgt_way;
  logic [1:0]       new_state, d_rel;
  logic             need_victim, need_inv, need_wb;
  logic             inst_go, inv_go, pipe_req, pipe_wb_sel, rel_go;

  fs_decode #(.WAY_W(WAY_W)) u_dec (
    .kind(c_kind), .excl(c_excl), .has_wr(c_wr), .own_way(c_way),
    .vict_way(vict_way), .vict_state(vict_state), .new_state(new_state),
    .tgt_way(tgt_way), .need_victim(need_victim), .need_inv(need_inv),
    .need_wb(need_wb), .rel_kind(d_rel)
  );

  fs_ctrl #(.SET_W(SET_W), .WAY_W(WAY_W), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rst(rst), .stall(stall_reply), .rep_valid(rep_valid),
    .rep_kind(rep_kind), .rep_excl(rep_excl), .rep_has_wr(rep_has_wr),
    .rep_set(rep_set), .rep_tag(rep_tag), .rep_way(rep_way), .rep_ready(rep_ready),
    .c_kind(c_kind), .c_excl(c_excl), .c_wr(c_wr), .c_set(c_set), .c_tag(c_tag),
    .c_way(c_way), .d_need_victim(need_victim), .d_need_inv(need_inv),
    .d_need_wb(need_wb), .vict_valid(vict_valid), .vict_tag(vict_tag),
    .l1_wb_mode(l1_wb_mode), .q_i_full(inv_i_full), .q_d_full(inv_d_full),
    .ack_valid(inv_ack_valid), .ack_wb(inv_ack_wb), .pipe_ready(pipe_ready),
    .inst_go(inst_go), .inv_go(inv_go), .pipe_req(pipe_req),
    .pipe_wb_sel(pipe_wb_sel), .rel_go(rel_go), .v_tag(v_tag)
  );

  fs_pipe_mux #(.SET_W(SET_W), .TAG_W(TAG_W)) u_mux (
    .req(pipe_req), .wb_sel(pipe_wb_sel), .set_i(c_set), .rep_tag(c_tag),
    .vic_tag(v_tag), .rep_kind(d_rel), .valid(pipe_valid), .kind(pipe_kind),
    .set_o(pipe_set), .tag(pipe_tag)
  );

  always_comb begin
    st_we      = inst_go;
    st_set     = c_set;
    st_way     = tgt_way;
    st_tag     = c_tag;
    st_state   = new_state;
    inv_i_push = inv_go;
    inv_d_push = inv_go;
    inv_set    = c_set;
    inv_tag    = v_tag;
    rel_valid  = rel_go;
    rel_kind   = d_rel;
  end
endmodule

// File: rtl/fs_chk.sv
module fs_chk #(
  parameter int TAG_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             stall_reply,
  input logic             rep_valid,
  input logic             rep_ready,
  input logic             inv_i_full,
  input logic             inv_d_full,
  input logic             inv_i_push,
  input logic             inv_d_push,
  input logic             pipe_valid,
  input logic             pipe_ready,
  input logic [1:0]       pipe_kind,
  input logic [TAG_W-1:0] pipe_tag,
  input logic             st_we,
  input logic [1:0]       st_state,
  input logic             rel_valid
);
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    rep_valid && rep_ready |=> !rep_ready);

  a_r4_no_invalid_fill: assert property (@(posedge clk) disable iff (rst)
    st_we |-> st_state != 2'd0);

  a_r7_push_needs_room: assert property (@(posedge clk) disable iff (rst)
    (inv_i_push || inv_d_push) |-> !inv_i_full && !inv_d_full);

  a_r10_pipe_hold: assert property (@(posedge clk) disable iff (rst)
    pipe_valid && !pipe_ready |=>
      (pipe_valid && $stable(pipe_kind) && $stable(pipe_tag)) || stall_reply);

  a_r11_release_with_reply: assert property (@(posedge clk) disable iff (rst)
    rel_valid |-> pipe_valid && pipe_ready && pipe_kind != 2'd3);

  a_r12_stall_quiet: assert property (@(posedge clk) disable iff (rst)
    stall_reply |-> !st_we && !inv_i_push && !inv_d_push && !pipe_valid && !rel_valid);
endmodule

bind fill_seq fs_chk #(.TAG_W(TAG_W)) u_fs_chk (
  .clk(clk), .rst(rst), .stall_reply(stall_reply), .rep_valid(rep_valid),
  .rep_ready(rep_ready), .inv_i_full(inv_i_full), .inv_d_full(inv_d_full),
  .inv_i_push(inv_i_push), .inv_d_push(inv_d_push), .pipe_valid(pipe_valid),
  .pipe_ready(pipe_ready), .pipe_kind(pipe_kind), .pipe_tag(pipe_tag),
  .st_we(st_we), .st_state(st_state), .rel_valid(rel_valid)
);

// File: tb/tb_fill_seq.sv
`timescale 1ns/1ps
module tb_fill_seq;
  localparam int SET_W = 8;
  localparam int WAY_W = 3;
  localparam int TAG_W = 20;
  localparam int HOLD  = 6;
  localparam logic [TAG_W-1:0] TAG_A = 20'hABCDE;
  localparam logic [TAG_W-1:0] TAG_V = 20'h12345;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic stall_reply = 0, rep_valid = 0, rep_ready, rep_excl = 0, rep_has_wr = 0;
  logic [1:0] rep_kind = 0, vict_state = 0;
  logic [SET_W-1:0] rep_set = 0;
  logic [TAG_W-1:0] rep_tag = 0, vict_tag = 0;
  logic [WAY_W-1:0] rep_way = 0, vict_way = 0;
  logic vict_valid = 1, l1_wb_mode = 0, inv_i_full = 0, inv_d_full = 0;
  logic inv_i_push, inv_d_push, inv_ack_valid = 0, inv_ack_wb = 0;
  logic [SET_W-1:0] inv_set, pipe_set, st_set;
  logic [TAG_W-1:0] inv_tag, pipe_tag, st_tag;
  logic pipe_valid, pipe_ready = 1, st_we, rel_valid;
  logic [1:0] pipe_kind, st_state, rel_kind;
  logic [WAY_W-1:0] st_way;

  fill_seq #(.SET_W(SET_W), .WAY_W(WAY_W), .TAG_W(TAG_W)) dut (.*);

  int n_chk = 0, n_fail = 0;
  int cyc = 0, n_st = 0, n_ii = 0, n_id = 0, n_wb = 0, n_rep = 0, n_rel = 0;
  int wb_cyc = 0, rep_cyc = 0, ack_cyc = 0;
  logic [1:0] l_st, l_rk, l_rel;
  logic [WAY_W-1:0] l_way;
  logic [TAG_W-1:0] l_wbtag, l_invtag;

  // events sampled 1 ns after the falling edge take effect at the next rising edge
  always begin
    @(negedge clk); #1;
    cyc++;
    if (!rst) begin
      if (st_we) begin n_st++; l_st = st_state; l_way = st_way; end
      if (inv_i_push) begin n_ii++; l_invtag = inv_tag; end
      if (inv_d_push) n_id++;
      if (inv_ack_valid) ack_cyc = cyc;
      if (pipe_valid && pipe_ready) begin
        if (pipe_kind == 2'd3) begin n_wb++; wb_cyc = cyc; l_wbtag = pipe_tag; end
        else begin n_rep++; rep_cyc = cyc; l_rk = pipe_kind; end
      end
      if (rel_valid) begin n_rel++; l_rel = rel_kind; end
    end
  end

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  int r_st, r_ii, r_id, r_wb, r_rep, r_rel, s_st, s_ii, s_id, s_wb, s_pv, s_pk;
  logic r_busy, r_done;

  // hmode: 0 none, 1 stall, 2 instruction queue full, 3 no victim, 4 pipe backpressure
  task automatic run_txn(input logic [1:0] kind, input logic ex, input logic wr,
                         input logic [1:0] vst, input logic wbm, input logic awb, input int hmode);
    int b_st, b_ii, b_id, b_wb, b_rep, b_rel, wait_n;
    bit acked;
    b_st = n_st; b_ii = n_ii; b_id = n_id; b_wb = n_wb; b_rep = n_rep; b_rel = n_rel;
    acked = 0; wait_n = 0; r_done = 0; r_busy = 1;
    @(negedge clk);
    rep_valid = 1; rep_kind = kind; rep_excl = ex; rep_has_wr = wr;
    rep_set = 8'h3C; rep_tag = TAG_A; rep_way = 3'd2;
    vict_state = vst; vict_way = 3'd5; vict_tag = TAG_V; l1_wb_mode = wbm;
    vict_valid = (hmode != 3); stall_reply = (hmode == 1);
    inv_i_full = (hmode == 2); pipe_ready = (hmode != 4);
    for (int c = 0; c < 80 && !r_done; c++) begin
      @(negedge clk);
      rep_valid = 0; inv_ack_valid = 0;
      if (c == 0) r_busy = rep_ready;
      if (c == HOLD) begin
        s_st = n_st - b_st; s_ii = n_ii - b_ii; s_id = n_id - b_id;
        s_wb = n_wb - b_wb; s_pv = int'(pipe_valid); s_pk = int'(pipe_kind);
        vict_valid = 1; stall_reply = 0; inv_i_full = 0; pipe_ready = 1;
      end
      if (wbm && (n_ii > b_ii) && !acked) begin
        wait_n++;
        if (wait_n == 3) begin inv_ack_valid = 1; inv_ack_wb = awb; acked = 1; end
      end
      #1.5;
      if (n_rel > b_rel) r_done = 1;
    end
    @(negedge clk);
    inv_ack_valid = 0;
    r_st = n_st - b_st; r_ii = n_ii - b_ii; r_id = n_id - b_id;
    r_wb = n_wb - b_wb; r_rep = n_rep - b_rep; r_rel = n_rel - b_rel;
    chk("R11", "transaction completed", int'(r_done), 1);
  endtask

  typedef struct packed {
    logic [1:0] kind; logic ex; logic wr; logic [1:0] vst; logic wbm; logic awb;
    logic [1:0] est; logic einv; logic ewb;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{2'd0, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0},
    '{2'd1, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0},
    '{2'd1, 1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0},
    '{2'd1, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0},
    '{2'd2, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0},
    '{2'd2, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0},
    '{2'd2, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 2'd3, 1'b1, 1'b1},
    '{2'd2, 1'b0, 1'b0, 2'd2, 1'b1, 1'b1, 2'd1, 1'b1, 1'b1},
    '{2'd2, 1'b1, 1'b0, 2'd2, 1'b1, 1'b0, 2'd2, 1'b1, 1'b0},
    '{2'd2, 1'b0, 1'b1, 2'd3, 1'b1, 1'b1, 2'd3, 1'b1, 1'b1}
  };

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk); #1.5;
    chk("R1", "rep_ready after reset", int'(rep_ready), 1);
    chk("R10", "pipe_valid after reset", int'(pipe_valid), 0);
    chk("R6", "no push after reset", int'(inv_i_push | inv_d_push), 0);
    chk("R4", "no line write after reset", int'(st_we), 0);

    foreach (VECS[i]) begin
      vec_t v;
      int exp_way, exp_rel;
      v = VECS[i];
      exp_way = (v.kind == 2'd2) ? 5 : 2;
      exp_rel = (v.kind == 2'd0) ? 2 : (v.ex ? 1 : 0);
      run_txn(v.kind, v.ex, v.wr, v.vst, v.wbm, v.awb, 0);
      chk("R1", "rep_ready low while busy", int'(r_busy), 0);
      chk("R5", "one line write", r_st, 1);
      chk("R4", "installed state", int'(l_st), int'(v.est));
      chk(v.kind == 2'd2 ? "R5" : "R3", "installed way", int'(l_way), exp_way);
      chk("R6", "instruction invalidations", r_ii, int'(v.einv));
      chk("R6", "data invalidations", r_id, int'(v.einv));
      if (v.einv) chk("R6", "invalidation tag", longint'(l_invtag), longint'(TAG_V));
      chk(v.wbm ? "R9" : "R8", "writebacks", r_wb, int'(v.ewb));
      if (v.ewb) begin
        chk("R8", "writeback tag", longint'(l_wbtag), longint'(TAG_V));
        chk("R8", "writeback before reply", int'(wb_cyc < rep_cyc), 1);
      end
      if (v.wbm && v.einv) chk("R9", "reply after acknowledge", int'(rep_cyc > ack_cyc), 1);
      chk("R11", "one reply", r_rep, 1);
      chk(v.kind == 2'd0 ? "R2" : "R11", "reply kind", int'(l_rk), exp_rel);
      chk("R11", "release kind", int'(l_rel), exp_rel);
      chk("R11", "one release", r_rel, 1);
    end

    run_txn(2'd2, 1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 1);
    chk("R12", "no line write while stalled", s_st, 0);
    chk("R12", "line written after stall", r_st, 1);
    chk("R12", "writeback after stall", r_wb, 1);

    run_txn(2'd2, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 2);
    chk("R7", "line written before queue frees", s_st, 1);
    chk("R7", "no instruction push while full", s_ii, 0);
    chk("R7", "no data push while other full", s_id, 0);
    chk("R7", "instruction push after free", r_ii, 1);
    chk("R7", "data push after free", r_id, 1);

    run_txn(2'd2, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 3);
    chk("R5", "no write without victim", s_st, 0);
    chk("R5", "write once victim ready", r_st, 1);

    run_txn(2'd2, 1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 4);
    chk("R10", "no writeback accepted under backpressure", s_wb, 0);
    chk("R10", "pipe_valid held", s_pv, 1);
    chk("R10", "held entry is writeback", s_pk, 3);
    chk("R10", "writeback after ready", r_wb, 1);
    chk("R10", "reply after ready", r_rep, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule